// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-redistribution SAR converter. A one-cycle start pulse arrives with a 4-bit source address and a bipolar flag. The block then walks a trial code from the top weight down to the bottom weight. At each step it reads a single comparator bit, and when all bits are resolved it writes the coded result into an output register. The end-of-conversion line stays low for the whole run and goes high on the clock edge that loads the result.

The trial code is driven out so that the capacitor array, or a model of it, can be set up. The comparator input reports whether the summing node sits above the trip point. Each step lasts a fixed number of clocks, set by a parameter, so every conversion takes the same time. One address puts the block into power-down, which performs no conversion. Three other addresses select internal test sources, and for these the block presents the ideal code so that a comparator model can be checked against it.

Top module: `sar_sequencer`

## Requirements
- R1: The first trial code of a conversion is 0x800, on the cycle in which `eoc` is first low. Bits are resolved from bit 11 down to bit 0.
- R2: At each decision, `cmp_high`=1 clears the bit under trial and `cmp_high`=0 keeps it set. The next lower bit is then set for the next trial, so a comparator that reports (trial > input) yields the input code.
- R3: A start accepted while `eoc` is high drives `eoc` low on the next clock. `eoc` returns high on the edge that updates `result`, exactly 12*STEP_CLKS clocks after the start edge.
- R4: Unipolar coding (`bipolar`=0): the minimum input reads 0x000, full scale reads 0xFFF and mid-scale (2048) reads 0x800.
- R5: Bipolar coding (`bipolar`=1) is the unipolar code with bit 11 inverted. Mid-scale reads 0x000, the minimum reads 0x800 and full scale reads 0x7FF.
- R6: `chan_sel` holds the address of the last start accepted while idle. For the test addresses 0xB, 0xC and 0xD, `test_valid`=1 and `test_code` is 0x800, 0x000 or 0xFFF respectively. For every other address `test_valid`=0.
- R7: A start with address 0xE (power-down) runs no conversion. `eoc` stays high and `result` keeps its previous value.
- R8: Inputs above full scale convert as 0xFFF and inputs below zero convert as 0x000 (unipolar).
- R9: A start pulse during a conversion is ignored. The result, the timing and `chan_sel` are the same as without it.
- R10: `abort` during a conversion returns `eoc` high on the next clock, with `trial` at 0x000 and `result` unchanged. A start in the same cycle as `abort` is ignored.
- R11: After reset, `eoc`=1, `result`=0x000, `trial`=0x000, `chan_sel`=0 and `test_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a conversion |
| addr | input | 4 | Source address latched on an accepted start |
| bipolar | input | 1 | 1 = code the result as sign-flipped MSB |
| abort | input | 1 | Stops a running conversion |
| cmp_high | input | 1 | Comparator: summing node above trip point |
| trial | output | 12 | Current trial code for the capacitor array |
| eoc | output | 1 | High when idle, low while converting |
| result | output | 12 | Last completed, coded conversion result |
| chan_sel | output | 4 | Latched source address |
| test_valid | output | 1 | Latched address is a self-test source |
| test_code | output | 12 | Ideal code of the selected self-test source |

## Verification
A wrong bit index or a wrong comparator sense shows up as a wrong `result` at the end of the conversion in which it happens, 12*STEP_CLKS clocks after the start. A step counter that is off by one shows up as a low period on `eoc` of the wrong length, and this is visible on the first conversion. A wrong bipolar or power-down decode changes `result` or `eoc` within one conversion. A mishandled abort or repeated start shows on `eoc` or `result` within one clock of the event or at the end of that conversion.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int WIDTH     = 12,
  parameter int STEP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       addr,
  input  logic             bipolar,
  input  logic             abort,
  input  logic             cmp_high,
  output logic [WIDTH-1:0] trial,
  output logic             eoc,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       chan_sel,
  output logic             test_valid,
  output logic [WIDTH-1:0] test_code
);
  localparam int IW = $clog2(WIDTH);
  localparam int CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam int CONV_CLKS = WIDTH * STEP_CLKS;
  localparam logic [IW-1:0] TOP_BIT = IW'(WIDTH - 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CLKS - 1);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] MSB_ONLY = ONE << (WIDTH - 1);
  localparam logic [3:0] ADDR_PD   = 4'hE;
  localparam logic [3:0] ADDR_HALF = 4'hB;
  localparam logic [3:0] ADDR_LOW  = 4'hC;
  localparam logic [3:0] ADDR_HIGH = 4'hD;

  logic             busy;
  logic             bip_q;
  logic [IW-1:0]    bit_idx;
  logic [CW-1:0]    step_cnt;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] decided;

  assign mask    = ONE << bit_idx;
  assign decided = cmp_high ? (trial & ~mask) : trial;
  assign eoc     = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bip_q    <= 1'b0;
      bit_idx  <= '0;
      step_cnt <= '0;
      trial    <= '0;
      result   <= '0;
      chan_sel <= '0;
    end else if (busy) begin
      if (abort) begin
        busy  <= 1'b0;
        trial <= '0;
      end else if (step_cnt == STEP_LAST) begin
        step_cnt <= '0;
        if (bit_idx == '0) begin
          result <= {decided[WIDTH-1] ^ bip_q, decided[WIDTH-2:0]};
          busy   <= 1'b0;
          trial  <= '0;
        end else begin
          trial   <= decided | (mask >> 1);
          bit_idx <= bit_idx - 1'b1;
        end
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end else if (start && !abort) begin
      chan_sel <= addr;
      if (addr != ADDR_PD) begin
        busy     <= 1'b1;
        bip_q    <= bipolar;
        bit_idx  <= TOP_BIT;
        step_cnt <= '0;
        trial    <= MSB_ONLY;
      end
    end
  end

  always_comb begin
    test_valid = 1'b1;
    case (chan_sel)
      ADDR_HALF: test_code = MSB_ONLY;
      ADDR_LOW:  test_code = '0;
      ADDR_HIGH: test_code = '1;
      default: begin
        test_valid = 1'b0;
        test_code  = '0;
      end
    endcase
  end

  logic [15:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || eoc) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1'b1;
  end

  assert_first_trial_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> trial == MSB_ONLY);

  assert_eoc_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && start && !abort && addr != ADDR_PD) |=> !eoc);

  assert_conv_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> low_cnt < 16'(CONV_CLKS));

  assert_result_on_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(eoc));

  assert_powerdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && start && addr == ADDR_PD) |=> eoc && $stable(result));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && abort) |=> eoc && trial == '0 && $stable(result));
endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
  localparam int W = 12;
  localparam int S = 2;
  localparam int CONV = W * S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] addr = '0;
  logic bipolar = 1'b0;
  logic abort = 1'b0;
  logic cmp_high;
  logic [W-1:0] trial, result, test_code;
  logic eoc, test_valid;
  logic [3:0] chan_sel;
  int vin = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_high = (int'(trial) > vin);

  sar_sequencer #(.WIDTH(W), .STEP_CLKS(S)) u_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .bipolar(bipolar),
    .abort(abort), .cmp_high(cmp_high), .trial(trial), .eoc(eoc),
    .result(result), .chan_sel(chan_sel), .test_valid(test_valid),
    .test_code(test_code));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v, input bit bip);
    int c;
    c = (v < 0) ? 0 : (v > 4095) ? 4095 : v;
    if (bip) c = c ^ 12'h800;
    return c;
  endfunction

  task automatic pulse_start(input logic [3:0] a, input bit bip);
    @(negedge clk);
    start = 1'b1; addr = a; bipolar = bip;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic convert(input logic [3:0] a, input bit bip, input int v,
                         input string req, input bit mid_start);
    int lows;
    lows = 0;
    vin = v;
    pulse_start(a, bip);
    check(eoc == 1'b0, "R3", eoc, 0);
    check(trial == 12'h800, "R1", trial, 12'h800);
    while (eoc == 1'b0 && lows < 1000) begin
      lows++;
      if (mid_start && lows == 7) begin
        start = 1'b1; addr = 4'h3; bipolar = ~bip;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(lows == CONV, "R3", lows, CONV);
    check(int'(result) == expect_code(v, bip), req, result, expect_code(v, bip));
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] saved;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    check(eoc == 1'b1, "R11", eoc, 1);
    check(result == '0, "R11", result, 0);
    check(trial == '0, "R11", trial, 0);
    check(chan_sel == 4'h0 && test_valid == 1'b0, "R11", {chan_sel, 3'b0, test_valid}, 0);
    rst_n = 1'b1;

    convert(4'h1, 1'b0, 0, "R4", 1'b0);
    convert(4'h2, 1'b0, 4095, "R4", 1'b0);
    convert(4'h3, 1'b0, 2048, "R4", 1'b0);
    convert(4'h4, 1'b0, 1365, "R2", 1'b0);
    convert(4'h5, 1'b1, 2048, "R5", 1'b0);
    convert(4'h5, 1'b1, 0, "R5", 1'b0);
    convert(4'h5, 1'b1, 4095, "R5", 1'b0);
    convert(4'h6, 1'b0, 5000, "R8", 1'b0);
    convert(4'h7, 1'b0, -300, "R8", 1'b0);

    convert(4'hB, 1'b0, 2048, "R6", 1'b0);
    check(test_valid && chan_sel == 4'hB, "R6", chan_sel, 4'hB);
    check(result == test_code && test_code == 12'h800, "R6", test_code, 12'h800);
    convert(4'hC, 1'b0, 0, "R6", 1'b0);
    check(test_valid && result == test_code && test_code == 12'h000, "R6", test_code, 0);
    convert(4'hD, 1'b0, 4095, "R6", 1'b0);
    check(test_valid && result == test_code && test_code == 12'hFFF, "R6", test_code, 12'hFFF);
    convert(4'h9, 1'b0, 100, "R2", 1'b0);
    check(test_valid == 1'b0 && chan_sel == 4'h9, "R6", {test_valid, chan_sel}, 4'h9);

    saved = result;
    vin = 3000;
    pulse_start(4'hE, 1'b0);
    check(eoc == 1'b1, "R7", eoc, 1);
    repeat (CONV + 2) @(negedge clk);
    check(eoc == 1'b1 && result == saved, "R7", result, saved);

    convert(4'hA, 1'b0, 777, "R9", 1'b1);
    check(chan_sel == 4'hA, "R9", chan_sel, 4'hA);

    saved = result;
    vin = 2500;
    pulse_start(4'h2, 1'b0);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    start = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    start = 1'b0;
    check(eoc == 1'b1, "R10", eoc, 1);
    check(trial == '0 && result == saved, "R10", result, saved);
    check(chan_sel == 4'h2, "R10", chan_sel, 4'h2);

    for (int i = 0; i < 40; i++) begin
      int v;
      v = int'($urandom_range(4500)) - 200;
      convert(4'($urandom_range(10)), 1'($urandom_range(1)), v, "R2", 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule